// File: doc/BRIEF.md
# Software Trap and Return Controller

This block sits beside the execute stage of a small processor and owns the privilege and exception state that software traps and returns from traps touch. When the core issues a trap instruction it presents a base and an offset; the block folds their sum into an upper range of interrupt numbers and pulses a software-interrupt request carrying that number. When the core issues a return from a trap, the block inspects the current supervisor bit, the trap-enable bit and its own debug-state flag, together with the debug-field bit of the instruction. It then restores the program counter and status from one of two sets of saved registers, or it resolves to the following instruction while flagging an illegal instruction or a halt.

Every outcome is registered: the next PC, the status bits and the strobes all appear one clock after the request is sampled. The core can also write the supervisor and trap-enable bits directly and can put the block into debug state. Fetch, decode and interrupt vectoring are handled elsewhere.

Top module: `swtrap_ctrl`

## Requirements
- R1: One cycle after trap_req_i is sampled high, sw_irq_o pulses for one cycle and sw_irq_num_o equals bit 7 set (0x80) ORed with the low 7 bits of trap_base_i + trap_ofs_i; sw_irq_num_o holds its value between traps.
- R2: A return sampled with supervisor bit s_o = 0 gives next_pc_o = pc_i + 4, raises no illegal strobe and leaves s_o, et_o and dbg_o unchanged.
- R3: A return sampled with s_o = 0 and et_o = 0 pulses halt_o for one cycle; with s_o = 0 and et_o = 1 halt_o stays low.
- R4: A return sampled with s_o = 1 and et_o = 1 pulses illegal_o for one cycle, gives next_pc_o = pc_i + 4 and changes no status bit.
- R5: A return sampled with s_o = 1, et_o = 0, dbg_o = 0 and ret_dbg_i = 0 gives next_pc_o = saved_pc_i, sets et_o to 1 and loads s_o from saved_ps_i.
- R6: A return sampled with s_o = 1, et_o = 0, dbg_o = 1 and ret_dbg_i = 1 gives next_pc_o = dbg_saved_pc_i, loads et_o from dbg_saved_et_i and s_o from dbg_saved_s_i, and clears dbg_o.
- R7: A return sampled with s_o = 1, et_o = 0 and dbg_o different from ret_dbg_i gives next_pc_o = pc_i + 4 and changes no status bit.
- R8: next_pc_vld_o pulses for exactly the cycle after each sampled return; next_pc_o holds its value in cycles without a return.
- R9: After reset s_o = 1, et_o = 0, dbg_o = 0, next_pc_o = 0, sw_irq_num_o = 0 and all strobes are low.
- R10: status_wr_i loads s_o and et_o from status_s_i and status_et_i unless a restoring return (R5 or R6) is sampled in the same cycle, which wins; dbg_enter_i sets dbg_o and wins over the clear of R6.
- R11: A trap and a return sampled in the same cycle are both carried out in full, each with the result it would have alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Trap instruction executes this cycle |
| trap_base_i | input | XLEN | Trap base operand |
| trap_ofs_i | input | XLEN | Trap offset operand |
| ret_req_i | input | 1 | Return-from-trap executes this cycle |
| ret_dbg_i | input | 1 | Debug-field bit of the return |
| pc_i | input | XLEN | PC of the current instruction |
| saved_pc_i | input | XLEN | Saved PC for a normal return |
| saved_ps_i | input | 1 | Saved previous-supervisor bit |
| dbg_saved_pc_i | input | XLEN | Saved PC for a debug return |
| dbg_saved_et_i | input | 1 | Saved trap-enable bit for a debug return |
| dbg_saved_s_i | input | 1 | Saved supervisor bit for a debug return |
| status_wr_i | input | 1 | Direct write of the status bits |
| status_s_i | input | 1 | Supervisor value for the direct write |
| status_et_i | input | 1 | Trap-enable value for the direct write |
| dbg_enter_i | input | 1 | Enter debug state |
| sw_irq_o | output | 1 | Software-interrupt request pulse |
| sw_irq_num_o | output | NUM_W | Software-interrupt number |
| next_pc_o | output | XLEN | PC chosen by the last return |
| next_pc_vld_o | output | 1 | next_pc_o updated this cycle |
| illegal_o | output | 1 | Illegal-instruction pulse |
| halt_o | output | 1 | Halt pulse |
| s_o | output | 1 | Supervisor bit |
| et_o | output | 1 | Trap-enable bit |
| dbg_o | output | 1 | Debug state |

## Verification
The functions that collide are a trap and a return issued in the same cycle, and also a return that restores status landing on the same edge as a direct status write or a debug entry. The bench drives long runs in which trap, return, status write and debug entry requests are each raised independently at random, so all of these coincidences occur many times, next to directed cases for each return path. A behavioural model in the bench predicts every output for every cycle from the stated priorities, and any disagreement on the interrupt number, the strobes, the PC or the status bits is reported against its requirement.

// File: rtl/swtrap_pkg.sv
package swtrap_pkg;
  typedef enum logic [2:0] {
    RK_FALL    = 3'd0,  // user mode, fault raised elsewhere
    RK_HALT    = 3'd1,  // user mode with traps off
    RK_ILLEGAL = 3'd2,
    RK_NORMAL  = 3'd3,
    RK_DEBUG   = 3'd4,
    RK_NOP     = 3'd5
  } ret_kind_e;
endpackage

// File: rtl/swtrap_num.sv
module swtrap_num #(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  ofs_i,
  output logic [NUM_W-1:0] num_o
);
  localparam int LOW_W = NUM_W - 1;

  logic [XLEN-1:0] sum;

  always_comb begin
    sum   = base_i + ofs_i;
    num_o = {1'b1, sum[LOW_W-1:0]};
  end
endmodule

// File: rtl/swtrap_ret_dec.sv
module swtrap_ret_dec
  import swtrap_pkg::*;
(
  input  logic      s_i,
  input  logic      et_i,
  input  logic      dbg_i,
  input  logic      field_i,
  output ret_kind_e kind_o
);
  // check order is significant
  always_comb begin
    if (!s_i)                  kind_o = et_i ? RK_FALL : RK_HALT;
    else if (et_i)             kind_o = RK_ILLEGAL;
    else if (!dbg_i && !field_i) kind_o = RK_NORMAL;
    else if (dbg_i && field_i) kind_o = RK_DEBUG;
    else                       kind_o = RK_NOP;
  end
endmodule

// File: rtl/swtrap_ctrl.sv
module swtrap_ctrl
  import swtrap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_req_i,
  input  logic [XLEN-1:0]  trap_base_i,
  input  logic [XLEN-1:0]  trap_ofs_i,
  input  logic             ret_req_i,
  input  logic             ret_dbg_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  saved_pc_i,
  input  logic             saved_ps_i,
  input  logic [XLEN-1:0]  dbg_saved_pc_i,
  input  logic             dbg_saved_et_i,
  input  logic             dbg_saved_s_i,
  input  logic             status_wr_i,
  input  logic             status_s_i,
  input  logic             status_et_i,
  input  logic             dbg_enter_i,
  output logic             sw_irq_o,
  output logic [NUM_W-1:0] sw_irq_num_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             next_pc_vld_o,
  output logic             illegal_o,
  output logic             halt_o,
  output logic             s_o,
  output logic             et_o,
  output logic             dbg_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [NUM_W-1:0] num_d;
  ret_kind_e        kind;
  logic [XLEN-1:0]  pc_d;
  logic             s_d, et_d, dbg_d;

  swtrap_num #(.XLEN(XLEN), .NUM_W(NUM_W)) u_num (
    .base_i (trap_base_i),
    .ofs_i  (trap_ofs_i),
    .num_o  (num_d)
  );

  swtrap_ret_dec u_dec (
    .s_i     (s_o),
    .et_i    (et_o),
    .dbg_i   (dbg_o),
    .field_i (ret_dbg_i),
    .kind_o  (kind)
  );

  always_comb begin
    pc_d  = pc_i + INSN_BYTES;
    s_d   = status_wr_i ? status_s_i  : s_o;
    et_d  = status_wr_i ? status_et_i : et_o;
    dbg_d = dbg_o;
    if (ret_req_i) begin
      unique case (kind)
        RK_NORMAL: begin
          pc_d = saved_pc_i;
          et_d = 1'b1;
          s_d  = saved_ps_i;
        end
        RK_DEBUG: begin
          pc_d  = dbg_saved_pc_i;
          et_d  = dbg_saved_et_i;
          s_d   = dbg_saved_s_i;
          dbg_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (dbg_enter_i) dbg_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_irq_o      <= 1'b0;
      sw_irq_num_o  <= '0;
      next_pc_o     <= '0;
      next_pc_vld_o <= 1'b0;
      illegal_o     <= 1'b0;
      halt_o        <= 1'b0;
      s_o           <= 1'b1;
      et_o          <= 1'b0;
      dbg_o         <= 1'b0;
    end else begin
      sw_irq_o      <= trap_req_i;
      if (trap_req_i) sw_irq_num_o <= num_d;
      next_pc_vld_o <= ret_req_i;
      if (ret_req_i) next_pc_o <= pc_d;
      illegal_o     <= ret_req_i && (kind == RK_ILLEGAL);
      halt_o        <= ret_req_i && (kind == RK_HALT);
      s_o           <= s_d;
      et_o          <= et_d;
      dbg_o         <= dbg_d;
    end
  end
endmodule

// File: rtl/swtrap_ctrl_chk.sv
module swtrap_ctrl_chk #(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trap_req_i,
  input logic [XLEN-1:0]  trap_base_i,
  input logic [XLEN-1:0]  trap_ofs_i,
  input logic             ret_req_i,
  input logic             ret_dbg_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  saved_pc_i,
  input logic             saved_ps_i,
  input logic [XLEN-1:0]  dbg_saved_pc_i,
  input logic             dbg_saved_et_i,
  input logic             dbg_saved_s_i,
  input logic             status_wr_i,
  input logic             status_s_i,
  input logic             status_et_i,
  input logic             dbg_enter_i,
  input logic             sw_irq_o,
  input logic [NUM_W-1:0] sw_irq_num_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             next_pc_vld_o,
  input logic             illegal_o,
  input logic             halt_o,
  input logic             s_o,
  input logic             et_o,
  input logic             dbg_o
);
  p_irq_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> sw_irq_o && sw_irq_num_o[NUM_W-1]);

  p_halt_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(ret_req_i) && !$past(s_o) && !$past(et_o));

  p_illegal_pc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && s_o && et_o |=> illegal_o && !halt_o && next_pc_o == $past(pc_i) + XLEN'(4));

  p_normal_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && s_o && !et_o && !dbg_o && !ret_dbg_i
      |=> et_o && next_pc_o == $past(saved_pc_i) && s_o == $past(saved_ps_i));

  p_debug_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && s_o && !et_o && dbg_o && ret_dbg_i && !dbg_enter_i |=> !dbg_o);

  p_mismatch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && s_o && !et_o && (dbg_o != ret_dbg_i) && !status_wr_i && !dbg_enter_i
      |=> $stable(s_o) && $stable(et_o) && $stable(dbg_o) && next_pc_o == $past(pc_i) + XLEN'(4));

  p_vld_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_req_i |=> !next_pc_vld_o && $stable(next_pc_o));

  p_strobes_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && halt_o));
endmodule

bind swtrap_ctrl swtrap_ctrl_chk #(.XLEN(XLEN), .NUM_W(NUM_W)) u_chk (.*);

// File: tb/swtrap_ctrl_tb_top.sv
module swtrap_ctrl_tb_top;
  localparam int XLEN  = 32;
  localparam int NUM_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trap_req_i = 0, ret_req_i = 0, ret_dbg_i = 0;
  logic [XLEN-1:0] trap_base_i = 0, trap_ofs_i = 0, pc_i = 0, saved_pc_i = 0, dbg_saved_pc_i = 0;
  logic saved_ps_i = 0, dbg_saved_et_i = 0, dbg_saved_s_i = 0;
  logic status_wr_i = 0, status_s_i = 0, status_et_i = 0, dbg_enter_i = 0;
  logic sw_irq_o, next_pc_vld_o, illegal_o, halt_o, s_o, et_o, dbg_o;
  logic [NUM_W-1:0] sw_irq_num_o;
  logic [XLEN-1:0]  next_pc_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  swtrap_ctrl #(.XLEN(XLEN), .NUM_W(NUM_W)) dut_i (.*);

  // behavioural reference
  logic            m_irq = 0, m_vld = 0, m_ill = 0, m_halt = 0;
  logic            m_s = 1, m_et = 0, m_dbg = 0;
  logic [7:0]      m_num = 0;
  logic [XLEN-1:0] m_pc = 0;
  string           m_tag = "R9 reset";

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_irq = 0; m_vld = 0; m_ill = 0; m_halt = 0;
      m_s = 1; m_et = 0; m_dbg = 0; m_num = 0; m_pc = 0; m_tag = "R9 reset";
    end else begin
      logic ns, net, ndbg;
      ns = m_s; net = m_et; ndbg = m_dbg;
      if (status_wr_i) begin ns = status_s_i; net = status_et_i; end
      m_irq = trap_req_i;
      if (trap_req_i) m_num = 8'h80 | 8'((trap_base_i + trap_ofs_i) & 32'h7f);
      m_vld = ret_req_i; m_ill = 0; m_halt = 0;
      m_tag = trap_req_i ? "R1 R10 idle/trap" : "R8 R10 idle";
      if (ret_req_i) begin
        if (trap_req_i) m_tag = "R11 trap+ret";
        if (m_s == 0) begin
          m_pc = pc_i + 4; m_halt = (m_et == 0);
          if (!trap_req_i) m_tag = m_et ? "R2 user ret" : "R3 halt ret";
        end else if (m_et) begin
          m_pc = pc_i + 4; m_ill = 1;
          if (!trap_req_i) m_tag = "R4 illegal ret";
        end else if (!m_dbg && !ret_dbg_i) begin
          m_pc = saved_pc_i; net = 1; ns = saved_ps_i;
          if (!trap_req_i) m_tag = "R5 normal ret";
        end else if (m_dbg && ret_dbg_i) begin
          m_pc = dbg_saved_pc_i; net = dbg_saved_et_i; ns = dbg_saved_s_i; ndbg = 0;
          if (!trap_req_i) m_tag = "R6 debug ret";
        end else begin
          m_pc = pc_i + 4;
          if (!trap_req_i) m_tag = "R7 mismatch ret";
        end
      end
      if (dbg_enter_i) ndbg = 1;
      m_s = ns; m_et = net; m_dbg = ndbg;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", m_tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("sw_irq", 64'(sw_irq_o), 64'(m_irq));
    chk("irq_num R1", 64'(sw_irq_num_o), 64'(m_num));
    chk("next_pc R8", 64'(next_pc_o), 64'(m_pc));
    chk("pc_vld R8", 64'(next_pc_vld_o), 64'(m_vld));
    chk("illegal R4", 64'(illegal_o), 64'(m_ill));
    chk("halt R3", 64'(halt_o), 64'(m_halt));
    chk("s R10", 64'(s_o), 64'(m_s));
    chk("et R10", 64'(et_o), 64'(m_et));
    chk("dbg R6", 64'(dbg_o), 64'(m_dbg));
  endtask

  // compare every cycle away from the edge
  always @(negedge clk_i) compare_all();

  task automatic clear_in();
    trap_req_i = 0; ret_req_i = 0; status_wr_i = 0; dbg_enter_i = 0;
  endtask

  task automatic step();
    @(negedge clk_i); #0.1;
  endtask

  task automatic set_status(input logic s, input logic et);
    clear_in(); status_wr_i = 1; status_s_i = s; status_et_i = et; step(); clear_in();
  endtask

  task automatic do_ret(input logic fld, input logic [XLEN-1:0] pc);
    clear_in(); ret_req_i = 1; ret_dbg_i = fld; pc_i = pc; step(); clear_in();
  endtask

  initial begin
    int unsigned cyc = 0;
    repeat (3) @(negedge clk_i);
    #0.1 rst_ni = 1;
    step();
    // R1 trap with wrap of the low bits
    trap_req_i = 1; trap_base_i = 32'hffff_fff0; trap_ofs_i = 32'h25; step(); clear_in();
    step();
    // R3 halt, R2 user fall-through
    saved_pc_i = 32'h1000; saved_ps_i = 1;
    set_status(0, 0); do_ret(0, 32'h200);
    set_status(0, 1); do_ret(0, 32'h204);
    // R4 illegal
    set_status(1, 1); do_ret(0, 32'h300);
    // R5 normal
    set_status(1, 0); do_ret(0, 32'h400);
    // R7 mismatch (not debug, field 1)
    set_status(1, 0); do_ret(1, 32'h500);
    // R6 debug return
    dbg_enter_i = 1; step(); clear_in();
    dbg_saved_pc_i = 32'h8000; dbg_saved_et_i = 1; dbg_saved_s_i = 0;
    do_ret(1, 32'h600);
    // R7 mismatch in debug, field 0
    dbg_enter_i = 1; step(); clear_in();
    set_status(1, 0); do_ret(0, 32'hffff_fffc);
    // R10 restoring return beats status write; R11 trap alongside
    ret_req_i = 1; ret_dbg_i = 1; status_wr_i = 1; status_s_i = 0; status_et_i = 0;
    dbg_enter_i = 1; trap_req_i = 1; trap_base_i = 5; trap_ofs_i = 7; step(); clear_in();
    step();
    // mid-run reset, R9
    @(negedge clk_i); rst_ni = 0; step(); step(); rst_ni = 1; step();
    // random mix
    repeat (4000) begin
      trap_req_i = ($urandom % 3) == 0; trap_base_i = $urandom; trap_ofs_i = $urandom;
      ret_req_i = ($urandom % 2) == 0; ret_dbg_i = $urandom; pc_i = $urandom;
      saved_pc_i = $urandom; saved_ps_i = $urandom;
      dbg_saved_pc_i = $urandom; dbg_saved_et_i = $urandom; dbg_saved_s_i = $urandom;
      status_wr_i = ($urandom % 4) == 0; status_s_i = $urandom; status_et_i = $urandom;
      dbg_enter_i = ($urandom % 5) == 0;
      step();
      cyc++;
    end
    clear_in(); step(); step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog R8: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule